// File: doc/BRIEF.md
# Indicator Bar and Character Line Register Block

This block is a small memory-mapped register slice that holds the state of an eight-lamp indicator bar and an eight-character text line. A host writes through a simple single-cycle register bus. The block presents the lamp byte and the eight character codes as plain parallel outputs, so that a separate driver can render them.

Two independent one-cycle strobes tell that driver what changed. One strobe covers the lamp bar and the other covers the text line. With separate strobes, a lamp update never forces a redraw of the text, and a text update never forces a redraw of the lamps.

The text line can be loaded in two ways. A single word write turns a 32-bit value into eight uppercase hexadecimal ASCII digits. A write to one of eight per-character registers replaces a single position and leaves the other seven as they were.

Top module: `dbg_panel_regs`

## Requirements
- R1: After reset, `lamps` is 0x00, every character is 0x20 (space), and both strobes are low.
- R2: A write to offset 0x408 stores bits [7:0] of the write data in `lamps`. Bits [31:8] of the data have no effect.
- R3: A write to offset 0x410 loads all eight characters with the uppercase hex ASCII digits of the 32-bit data. Nibble [31:28] goes to position 0 and nibble [3:0] goes to position 7. Digits 0-9 map to 0x30-0x39 and digits A-F map to 0x41-0x46.
- R4: Offsets 0x418 + 8*k, for k = 0 to 7, are character positions k. A write there stores data bits [7:0] at position k only, and the other seven positions keep their values.
- R5: A write to 0x408 raises `lamp_refresh` and does not raise `text_refresh`. A write to 0x410 or to any character position raises `text_refresh` and does not raise `lamp_refresh`.
- R6: Each strobe is high for exactly one clock, in the cycle that follows the accepted write. A strobe is never high in two consecutive cycles unless a write was accepted in each of those cycles.
- R7: A write to any other offset, including offsets between character positions such as 0x41C, changes no output and raises no strobe.
- R8: `rd_data` is combinational. Reading 0x408 returns the lamp byte zero-extended. Reading a character position returns that character zero-extended. Reading any other offset returns 0.
- R9: `chars` packs position k into bits [8k+7:8k]. `lamps` bit 7 is the leftmost lamp and bit 0 is the rightmost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| lamps | output | 8 | Lamp bar state, bit 7 leftmost |
| chars | output | 64 | Eight character codes, position k in bits [8k+7:8k] |
| lamp_refresh | output | 1 | One-cycle lamp redraw strobe |
| text_refresh | output | 1 | One-cycle text redraw strobe |

## Verification
A mis-decoded offset shows up in the cycle right after the write. Either the wrong character slot changes or a slot fails to change, and the wrong strobe may fire. A wrong hex conversion shows as a bad ASCII code at a known position after a single word write, and letters are the most exposed digits. Stale or leaking strobe state shows as a strobe that lasts two cycles, or as a strobe that fires after a write that should have been ignored. The bench looks at outputs and readback one cycle after every write.

// File: rtl/dbg_panel_pkg.sv
package dbg_panel_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NCHAR    = 8;
  localparam int CHAR_W   = 8;
  localparam int NIB_W    = 4;

  localparam logic [ADDR_W-1:0] OFF_LAMP  = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_HEXW  = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_CHAR0 = 12'h418;
  localparam int CHAR_STRIDE_LG = 3;

  localparam logic [CHAR_W-1:0] BLANK = 8'h20;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LAMP = 2'd1,
    SEL_HEXW = 2'd2,
    SEL_CHAR = 2'd3
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [2:0] pos;
  } dec_t;

  function automatic logic [CHAR_W-1:0] nib_to_ascii(input logic [NIB_W-1:0] n);
    if (n < 4'd10) return CHAR_W'(8'h30 + {4'h0, n});
    else           return CHAR_W'(8'h37 + {4'h0, n});
  endfunction

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    logic [ADDR_W-1:0] rel;
    d.sel = SEL_NONE;
    d.pos = '0;
    rel = a - OFF_CHAR0;
    if (a == OFF_LAMP) d.sel = SEL_LAMP;
    else if (a == OFF_HEXW) d.sel = SEL_HEXW;
    else if (a >= OFF_CHAR0 && rel[CHAR_STRIDE_LG-1:0] == '0 &&
             (rel >> CHAR_STRIDE_LG) < ADDR_W'(NCHAR)) begin
      d.sel = SEL_CHAR;
      d.pos = rel[CHAR_STRIDE_LG +: 3];
    end
    return d;
  endfunction
endpackage

// File: rtl/dbg_panel_decode.sv
module dbg_panel_decode
  import dbg_panel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [2:0]        pos
);
  dec_t d;
  always_comb begin
    d   = decode(addr);
    sel = d.sel;
    pos = d.pos;
  end
endmodule

// File: rtl/dbg_panel_lamp.sv
module dbg_panel_lamp
  import dbg_panel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        lamps,
  output logic              strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamps  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= hit;
      if (hit) lamps <= data[7:0];
    end
  end

  p_strobe_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> strobe);
  p_lamp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(lamps));
endmodule

// File: rtl/dbg_panel_text.sv
module dbg_panel_text
  import dbg_panel_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit_word,
  input  logic                    hit_char,
  input  logic [2:0]              pos,
  input  logic [DATA_W-1:0]       data,
  output logic [NCHAR*CHAR_W-1:0] chars,
  output logic                    strobe
);
  logic [NCHAR*CHAR_W-1:0] hex_line;

  genvar k;
  generate
    for (k = 0; k < NCHAR; k++) begin : g_slot
      assign hex_line[k*CHAR_W +: CHAR_W] =
        nib_to_ascii(data[(NCHAR-1-k)*NIB_W +: NIB_W]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chars[k*CHAR_W +: CHAR_W] <= BLANK;
        else if (hit_word) chars[k*CHAR_W +: CHAR_W] <= hex_line[k*CHAR_W +: CHAR_W];
        else if (hit_char && pos == 3'(k)) chars[k*CHAR_W +: CHAR_W] <= data[CHAR_W-1:0];
      end

      p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_word && !(hit_char && pos == 3'(k))) |=> $stable(chars[k*CHAR_W +: CHAR_W]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= hit_word | hit_char;
  end

  p_text_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_word || hit_char) |=> strobe);
endmodule

// File: rtl/dbg_panel_regs.sv
module dbg_panel_regs
  import dbg_panel_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [7:0]              lamps,
  output logic [NCHAR*CHAR_W-1:0] chars,
  output logic                    lamp_refresh,
  output logic                    text_refresh
);
  sel_e       wsel, rsel;
  logic [2:0] wpos, rpos;
  logic       hit_lamp, hit_word, hit_char;

  dbg_panel_decode u_wdec (.addr(wr_addr), .sel(wsel), .pos(wpos));
  dbg_panel_decode u_rdec (.addr(rd_addr), .sel(rsel), .pos(rpos));

  assign hit_lamp = wr_en && wsel == SEL_LAMP;
  assign hit_word = wr_en && wsel == SEL_HEXW;
  assign hit_char = wr_en && wsel == SEL_CHAR;

  dbg_panel_lamp u_lamp (
    .clk(clk), .rst_n(rst_n), .hit(hit_lamp), .data(wr_data),
    .lamps(lamps), .strobe(lamp_refresh));

  dbg_panel_text u_text (
    .clk(clk), .rst_n(rst_n), .hit_word(hit_word), .hit_char(hit_char),
    .pos(wpos), .data(wr_data), .chars(chars), .strobe(text_refresh));

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_LAMP: rd_data = {24'h0, lamps};
      SEL_CHAR: rd_data = {24'h0, chars[rpos*CHAR_W +: CHAR_W]};
      default:  rd_data = '0;
    endcase
  end

  p_one_hot_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_lamp, hit_word, hit_char}));
  p_no_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_lamp || hit_word || hit_char) |=> (!lamp_refresh && !text_refresh));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_refresh && !$past(hit_lamp)) == 1'b0);
endmodule

// File: tb/dbg_panel_regs_bench.sv
`timescale 1ns/1ps
module dbg_panel_regs_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0] lamps;
  logic [63:0] chars;
  logic lamp_refresh, text_refresh;
  int total = 0, bad = 0;
  logic [63:0] model;
  logic [7:0] mlamp;

  always #10 clk = ~clk;

  dbg_panel_regs u_dbg_panel_regs (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(logic [3:0] n);
    return (n <= 9) ? 8'd48 + n : 8'd65 + (n - 10);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d, output logic lr, output logic tr);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; lr = lamp_refresh; tr = text_refresh;
  endtask

  task automatic check_state(string req);
    chk(req, lamps, mlamp);
    chk(req, chars, model);
    for (int k = 0; k < 8; k++) begin
      rd_addr = 12'h418 + 12'(8*k); #1;
      chk(req, rd_data, {24'h0, model[8*k +: 8]});
    end
    rd_addr = 12'h408; #1; chk(req, rd_data, {24'h0, mlamp});
  endtask

  task automatic t_reset;
    chk("R1", {lamps, 6'b0, lamp_refresh, text_refresh}, 16'h0000);
    chk("R1", chars, {8{8'h20}});
    mlamp = 0; model = {8{8'h20}};
  endtask

  task automatic t_lamp;
    logic lr, tr;
    wr(12'h408, 32'hDEAD_BEA5, lr, tr); mlamp = 8'hA5;
    chk("R5", {lr, tr}, 2'b10);
    chk("R2", lamps, 8'hA5);
    chk("R9", lamps[7], 1'b1);
    @(negedge clk); chk("R6", lamp_refresh, 0);
    check_state("R8");
  endtask

  task automatic t_word(logic [31:0] v);
    logic lr, tr;
    wr(12'h410, v, lr, tr);
    for (int k = 0; k < 8; k++) model[8*k +: 8] = hexc(v[31-4*k -: 4]);
    chk("R5", {lr, tr}, 2'b01);
    chk("R3", chars, model);
    @(negedge clk); chk("R6", text_refresh, 0);
  endtask

  task automatic t_char;
    logic lr, tr;
    for (int k = 0; k < 8; k++) begin
      wr(12'h418 + 12'(8*k), 32'hFFFF_FF00 | 32'(8'h61 + k), lr, tr);
      model[8*k +: 8] = 8'h61 + 8'(k);
      chk("R4", chars, model);
      chk("R5", {lr, tr}, 2'b01);
    end
    check_state("R4");
  endtask

  task automatic t_ignored;
    logic lr, tr;
    logic [11:0] bads [6] = '{12'h41C, 12'h400, 12'h458, 12'h409, 12'h000, 12'h414};
    foreach (bads[i]) begin
      wr(bads[i], 32'h5A5A_5A5A, lr, tr);
      chk("R7", {lr, tr}, 2'b00);
      chk("R7", chars, model);
      chk("R7", lamps, mlamp);
      rd_addr = bads[i]; #1; chk("R8", rd_data, 0);
    end
  endtask

  task automatic t_back2back;
    @(negedge clk); wr_en = 1; wr_addr = 12'h408; wr_data = 32'h1;
    @(negedge clk); wr_data = 32'h2; chk("R6", lamp_refresh, 1);
    @(negedge clk); wr_en = 0; chk("R6", lamp_refresh, 1); chk("R2", lamps, 8'h2);
    @(negedge clk); chk("R6", lamp_refresh, 0);
    mlamp = 8'h2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk); chk("R1", {lamp_refresh, text_refresh}, 2'b00);
    t_lamp();
    t_word(32'h0123_4567);
    t_word(32'h89AB_CDEF);
    t_word(32'hF00D_0A9C);
    check_state("R3");
    t_char();
    t_ignored();
    t_back2back();
    check_state("R2");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule